// File: doc/BRIEF.md
# Instruction Prefix and Opcode Parser

This block sits at the front of a variable-length instruction decoder. It takes instruction bytes one at a time over a valid/ready handshake. It first soaks up any run of leading modifier bytes: operand-size toggle, address-size toggle, repeat, lock and segment selection. It then latches the opcode. A 0x0F escape byte is followed by one more opcode byte.

For every opcode the parser issues exactly one request on a combinational attribute lookup port. The answer says three things: whether an operand-descriptor byte follows, how many bytes each of the two immediates takes, and whether the opcode is undefined. If a descriptor byte follows, the parser starts a separate descriptor decoder with a one-cycle start pulse. It stops taking stream bytes until that decoder reports done, together with the descriptor byte, an index-byte flag and the displacement byte count. The parser then collects the second immediate, then the first. It ends the instruction with a one-cycle done pulse, during which all decoded fields and the total byte length are valid.

Top module: `insn_prefix_parser`

## Requirements
- R1: After reset, inReady is 1, and done, invalid, dscStart and lkReq are all 0.
- R2: Byte 0x66 sets opOvr, and opWide becomes the inverse of cfgOpWide. Byte 0x67 does the same with addrOvr, addrWide and cfgAddrWide. A repeated toggle byte leaves the size inverted; it does not toggle the size back.
- R3: Bytes 0xF2 and 0xF3 are stored in repByte, and the last one received wins. repByte reads 0 when neither byte appeared. Byte 0xF0 sets lockSeen.
- R4: Segment bytes map to segCode as follows: 0x26 gives 0, 0x2E gives 1, 0x36 gives 2, 0x3E gives 3, 0x64 gives 4 and 0x65 gives 5. Each one sets segValid, and the last one received wins.
- R5: The first byte that is not a modifier is the opcode. If that byte is 0x0F, the next byte is stored in subOp and hasSub is set, and the lookup is made with lkEscape=1 and lkOpcode=subOp.
- R6: If hasDesc is set, regIdx is bits 5:3 of dscByte. Otherwise regIdx is bits 2:0 of subOp when hasSub is set, and bits 2:0 of the opcode when it is not.
- R7: condCode is the low nibble of subOp when hasSub is set, and the low nibble of the opcode otherwise.
- R8: The immediate size codes are: 0 for none, 1, 2 and 4 for that many bytes, and 7 for 4 bytes when addrWide=1 or 2 bytes when addrWide=0. Any other code means no bytes.
- R9: The second immediate is taken from the stream before the first. Each immediate is assembled little-endian, so its first byte lands in bits 7:0.
- R10: length equals 1, plus hasSub, plus (1 + dscHasSib + dscDispBytes) when hasDesc is set, plus both immediate byte counts, plus the number of modifier bytes.
- R11: A lookup that reports a descriptor byte produces a single-cycle dscStart. inReady then stays 0 until dscDone, and the immediates follow after that.
- R12: done is a one-cycle pulse. In the cycle after done, every modifier flag is cleared and parsing of the next instruction begins.
- R13: A lookup that reports an undefined opcode produces a one-cycle invalid pulse without done. All modifier state is cleared before the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgOpWide | input | 1 | Default operand size is wide (held stable during an instruction) |
| cfgAddrWide | input | 1 | Default address size is wide (held stable during an instruction) |
| inByte | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte present |
| inReady | output | 1 | Parser accepts a stream byte |
| lkReq | output | 1 | Attribute lookup in progress this cycle |
| lkEscape | output | 1 | Lookup targets the escape table |
| lkOpWide | output | 1 | Effective operand size for the lookup |
| lkOpcode | output | 8 | Opcode or sub-opcode being looked up |
| lkHasDesc | input | 1 | Looked-up opcode carries a descriptor byte |
| lkImm1Code | input | 3 | Size code for the first immediate |
| lkImm2Code | input | 3 | Size code for the second immediate |
| lkUndefined | input | 1 | Looked-up opcode is undefined |
| dscStart | output | 1 | Start pulse to the descriptor decoder |
| dscAddrWide | output | 1 | Effective address size for the descriptor decoder |
| dscDone | input | 1 | Descriptor decoder finished |
| dscByte | input | 8 | Descriptor byte, valid with dscDone |
| dscHasSib | input | 1 | An index byte was consumed, valid with dscDone |
| dscDispBytes | input | 3 | Displacement bytes consumed, valid with dscDone |
| done | output | 1 | Instruction complete, fields valid |
| invalid | output | 1 | Undefined opcode seen |
| opWide | output | 1 | Effective operand size |
| addrWide | output | 1 | Effective address size |
| opOvr | output | 1 | Operand-size toggle byte seen |
| addrOvr | output | 1 | Address-size toggle byte seen |
| lockSeen | output | 1 | Lock byte seen |
| repByte | output | 8 | Last repeat byte, 0 if none |
| segValid | output | 1 | Segment byte seen |
| segCode | output | 3 | Selected segment code |
| opcode | output | 8 | Primary opcode byte |
| subOp | output | 8 | Byte after the escape |
| hasSub | output | 1 | Escape form in use |
| hasDesc | output | 1 | Descriptor byte present |
| regIdx | output | 3 | Register index |
| condCode | output | 4 | Condition nibble |
| imm1 | output | IMM_W | First immediate |
| imm2 | output | IMM_W | Second immediate |
| length | output | LEN_W | Total instruction length in bytes |

## Verification
The bench uses the default parameters: LEN_W of 8 and IMM_W of 32. With these, the 4-byte immediate path and the address-size code in both widths can be reached. So can a length of twelve bytes, which combines a modifier, the descriptor, an index byte, a four-byte displacement and a four-byte immediate. A bench-side lookup table is keyed by operand size. It drives the escape table, the out-of-range size code and undefined opcodes in both tables. A scripted descriptor decoder exercises the stall on inReady during the handoff.

// File: rtl/ipp_pkg.sv
package ipp_pkg;

  typedef enum logic [3:0] {
    S_PFX, S_SUB, S_LOOK, S_DGO, S_DWAIT, S_IMM2, S_IMM1, S_DONE, S_BAD
  } state_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic clr;
    logic takePfx;
    logic takeOp;
    logic takeSub;
    logic takeAttr;
    logic takeDesc;
    logic takeImm2;
    logic takeImm1;
    logic cntClr;
  } strobe_t;

  localparam logic [2:0] IMM_CODE_ADDR = 3'd7;
  localparam logic [7:0] ESC_BYTE      = 8'h0F;

  function automatic logic segHit(input logic [7:0] b);
    return (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) ||
           (b == 8'h3E) || (b == 8'h64) || (b == 8'h65);
  endfunction

  function automatic logic [2:0] segOf(input logic [7:0] b);
    case (b)
      8'h26:   return 3'd0;
      8'h2E:   return 3'd1;
      8'h36:   return 3'd2;
      8'h3E:   return 3'd3;
      8'h64:   return 3'd4;
      8'h65:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic isModifier(input logic [7:0] b);
    return (b == 8'h66) || (b == 8'h67) || (b == 8'hF2) ||
           (b == 8'hF3) || (b == 8'hF0) || segHit(b);
  endfunction

  function automatic logic [2:0] immBytes(input logic [2:0] code, input logic aw);
    case (code)
      3'd1:          return 3'd1;
      3'd2:          return 3'd2;
      3'd4:          return 3'd4;
      IMM_CODE_ADDR: return aw ? 3'd4 : 3'd2;
      default:       return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ipp_datapath.sv
module ipp_datapath
  import ipp_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [7:0]       inByte,
  input  logic             cfgOpWide,
  input  logic             cfgAddrWide,
  input  logic             lkHasDesc,
  input  logic [2:0]       lkImm1Code,
  input  logic [2:0]       lkImm2Code,
  input  logic [7:0]       dscByte,
  input  logic             dscHasSib,
  input  logic [2:0]       dscDispBytes,
  output logic             opWide,
  output logic             addrWide,
  output logic             opOvr,
  output logic             addrOvr,
  output logic             lockSeen,
  output logic [7:0]       repByte,
  output logic             segValid,
  output logic [2:0]       segCode,
  output logic [7:0]       opcode,
  output logic [7:0]       subOp,
  output logic             hasSub,
  output logic             hasDesc,
  output logic [2:0]       regIdx,
  output logic [3:0]       condCode,
  output logic [IMM_W-1:0] imm1,
  output logic [IMM_W-1:0] imm2,
  output logic [2:0]       imm1Bytes,
  output logic [2:0]       imm2Bytes,
  output logic [2:0]       immCnt,
  output logic [LEN_W-1:0] length
);

  localparam int SHIFT_W = $clog2(IMM_W);

  logic [LEN_W-1:0] pfxCnt;
  logic [7:0]       descByte;
  logic             descSib;
  logic [2:0]       descDisp;
  logic [IMM_W-1:0] immByteShifted;

  assign immByteShifted = IMM_W'(inByte) << SHIFT_W'({immCnt, 3'b000});

  always_ff @(posedge clk) begin
    if (!rstN || stb.clr) begin
      opOvr     <= 1'b0;
      addrOvr   <= 1'b0;
      lockSeen  <= 1'b0;
      repByte   <= 8'h00;
      segValid  <= 1'b0;
      segCode   <= 3'd0;
      opcode    <= 8'h00;
      subOp     <= 8'h00;
      hasSub    <= 1'b0;
      hasDesc   <= 1'b0;
      descByte  <= 8'h00;
      descSib   <= 1'b0;
      descDisp  <= 3'd0;
      imm1      <= '0;
      imm2      <= '0;
      imm1Bytes <= 3'd0;
      imm2Bytes <= 3'd0;
      immCnt    <= 3'd0;
      pfxCnt    <= '0;
    end else begin
      if (stb.takePfx) begin
        pfxCnt <= pfxCnt + LEN_W'(1);
        case (inByte)
          8'h66:        opOvr    <= 1'b1;
          8'h67:        addrOvr  <= 1'b1;
          8'hF2, 8'hF3: repByte  <= inByte;
          8'hF0:        lockSeen <= 1'b1;
          default: begin
            if (segHit(inByte)) begin
              segValid <= 1'b1;
              segCode  <= segOf(inByte);
            end
          end
        endcase
      end
      if (stb.takeOp) opcode <= inByte;
      if (stb.takeSub) begin
        subOp  <= inByte;
        hasSub <= 1'b1;
      end
      if (stb.takeAttr) begin
        hasDesc   <= lkHasDesc;
        imm1Bytes <= immBytes(lkImm1Code, addrWide);
        imm2Bytes <= immBytes(lkImm2Code, addrWide);
      end
      if (stb.takeDesc) begin
        descByte <= dscByte;
        descSib  <= dscHasSib;
        descDisp <= dscDispBytes;
      end
      if (stb.takeImm2) imm2 <= imm2 | immByteShifted;
      if (stb.takeImm1) imm1 <= imm1 | immByteShifted;
      if (stb.cntClr || stb.takeAttr) immCnt <= 3'd0;
      else if (stb.takeImm1 || stb.takeImm2) immCnt <= immCnt + 3'd1;
    end
  end

  assign opWide   = cfgOpWide ^ opOvr;
  assign addrWide = cfgAddrWide ^ addrOvr;

  always_comb begin
    if (hasDesc)     regIdx = descByte[5:3];
    else if (hasSub) regIdx = subOp[2:0];
    else             regIdx = opcode[2:0];
    condCode = hasSub ? subOp[3:0] : opcode[3:0];
  end

  assign length = LEN_W'(1) + LEN_W'(hasSub)
                + (hasDesc ? (LEN_W'(1) + LEN_W'(descSib) + LEN_W'(descDisp)) : '0)
                + LEN_W'(imm1Bytes) + LEN_W'(imm2Bytes) + pfxCnt;

  // R9: an immediate never collects more bytes than its size allows
  a_r9_imm1_bound: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeImm1 |-> (immCnt < imm1Bytes)) else $error("imm1 overrun");
  a_r9_imm2_bound: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeImm2 |-> (immCnt < imm2Bytes)) else $error("imm2 overrun");
  // R12: clearing leaves no modifier state behind
  a_r12_cleared: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (pfxCnt == '0 && !lockSeen && !segValid && repByte == 8'h00))
    else $error("modifier state survived clear");

endmodule

// File: rtl/ipp_ctrl.sv
module ipp_ctrl
  import ipp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inValid,
  input  logic       addrWide,
  input  logic       lkHasDesc,
  input  logic [2:0] lkImm1Code,
  input  logic [2:0] lkImm2Code,
  input  logic       lkUndefined,
  input  logic       dscDone,
  input  logic [2:0] imm1Bytes,
  input  logic [2:0] imm2Bytes,
  input  logic [2:0] immCnt,
  output strobe_t    stb,
  output logic       inReady,
  output logic       lkReq,
  output logic       dscStart,
  output logic       done,
  output logic       invalid
);

  state_t state, nxt;

  function automatic state_t afterDesc(input logic [2:0] b2, input logic [2:0] b1);
    if (b2 != 3'd0)      return S_IMM2;
    else if (b1 != 3'd0) return S_IMM1;
    else                 return S_DONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_PFX;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    stb      = '0;
    inReady  = 1'b0;
    lkReq    = 1'b0;
    dscStart = 1'b0;
    done     = 1'b0;
    invalid  = 1'b0;
    case (state)
      S_PFX: begin
        inReady = 1'b1;
        if (inValid) begin
          if (isModifier(inByte)) stb.takePfx = 1'b1;
          else begin
            stb.takeOp = 1'b1;
            nxt = (inByte == ESC_BYTE) ? S_SUB : S_LOOK;
          end
        end
      end
      S_SUB: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.takeSub = 1'b1;
          nxt = S_LOOK;
        end
      end
      S_LOOK: begin
        lkReq = 1'b1;
        if (lkUndefined) nxt = S_BAD;
        else begin
          stb.takeAttr = 1'b1;
          nxt = lkHasDesc ? S_DGO
              : afterDesc(immBytes(lkImm2Code, addrWide), immBytes(lkImm1Code, addrWide));
        end
      end
      S_DGO: begin
        dscStart = 1'b1;
        nxt = S_DWAIT;
      end
      S_DWAIT: begin
        if (dscDone) begin
          stb.takeDesc = 1'b1;
          nxt = afterDesc(imm2Bytes, imm1Bytes);
        end
      end
      S_IMM2: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.takeImm2 = 1'b1;
          if (immCnt == imm2Bytes - 3'd1) begin
            stb.cntClr = 1'b1;
            nxt = (imm1Bytes != 3'd0) ? S_IMM1 : S_DONE;
          end
        end
      end
      S_IMM1: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.takeImm1 = 1'b1;
          if (immCnt == imm1Bytes - 3'd1) nxt = S_DONE;
        end
      end
      S_DONE: begin
        done    = 1'b1;
        stb.clr = 1'b1;
        nxt     = S_PFX;
      end
      S_BAD: begin
        invalid = 1'b1;
        stb.clr = 1'b1;
        nxt     = S_PFX;
      end
      default: nxt = S_PFX;
    endcase
  end

  // R12: done lasts one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done held");
  // R11: start is a single pulse and the stream stays stalled after it
  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dscStart |=> (!dscStart && !inReady)) else $error("start misbehaved");
  // R13: invalid returns to accepting bytes
  a_r13_back_idle: assert property (@(posedge clk) disable iff (!rstN)
    invalid |=> (inReady && !invalid && !done)) else $error("no return after invalid");
  // R5: a lookup never runs while bytes are accepted
  a_r5_lookup_stall: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |-> !inReady) else $error("lookup overlaps stream");

endmodule

// File: rtl/insn_prefix_parser.sv
module insn_prefix_parser
  import ipp_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgOpWide,
  input  logic             cfgAddrWide,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  output logic             inReady,
  output logic             lkReq,
  output logic             lkEscape,
  output logic             lkOpWide,
  output logic [7:0]       lkOpcode,
  input  logic             lkHasDesc,
  input  logic [2:0]       lkImm1Code,
  input  logic [2:0]       lkImm2Code,
  input  logic             lkUndefined,
  output logic             dscStart,
  output logic             dscAddrWide,
  input  logic             dscDone,
  input  logic [7:0]       dscByte,
  input  logic             dscHasSib,
  input  logic [2:0]       dscDispBytes,
  output logic             done,
  output logic             invalid,
  output logic             opWide,
  output logic             addrWide,
  output logic             opOvr,
  output logic             addrOvr,
  output logic             lockSeen,
  output logic [7:0]       repByte,
  output logic             segValid,
  output logic [2:0]       segCode,
  output logic [7:0]       opcode,
  output logic [7:0]       subOp,
  output logic             hasSub,
  output logic             hasDesc,
  output logic [2:0]       regIdx,
  output logic [3:0]       condCode,
  output logic [IMM_W-1:0] imm1,
  output logic [IMM_W-1:0] imm2,
  output logic [LEN_W-1:0] length
);

  strobe_t    stb;
  logic [2:0] imm1Bytes, imm2Bytes, immCnt;

  ipp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .addrWide(addrWide), .lkHasDesc(lkHasDesc), .lkImm1Code(lkImm1Code),
    .lkImm2Code(lkImm2Code), .lkUndefined(lkUndefined), .dscDone(dscDone),
    .imm1Bytes(imm1Bytes), .imm2Bytes(imm2Bytes), .immCnt(immCnt),
    .stb(stb), .inReady(inReady), .lkReq(lkReq), .dscStart(dscStart),
    .done(done), .invalid(invalid)
  );

  ipp_datapath #(.LEN_W(LEN_W), .IMM_W(IMM_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inByte(inByte),
    .cfgOpWide(cfgOpWide), .cfgAddrWide(cfgAddrWide),
    .lkHasDesc(lkHasDesc), .lkImm1Code(lkImm1Code), .lkImm2Code(lkImm2Code),
    .dscByte(dscByte), .dscHasSib(dscHasSib), .dscDispBytes(dscDispBytes),
    .opWide(opWide), .addrWide(addrWide), .opOvr(opOvr), .addrOvr(addrOvr),
    .lockSeen(lockSeen), .repByte(repByte), .segValid(segValid), .segCode(segCode),
    .opcode(opcode), .subOp(subOp), .hasSub(hasSub), .hasDesc(hasDesc),
    .regIdx(regIdx), .condCode(condCode), .imm1(imm1), .imm2(imm2),
    .imm1Bytes(imm1Bytes), .imm2Bytes(imm2Bytes), .immCnt(immCnt), .length(length)
  );

  assign lkEscape    = hasSub;
  assign lkOpcode    = hasSub ? subOp : opcode;
  assign lkOpWide    = opWide;
  assign dscAddrWide = addrWide;

endmodule

// File: tb/insn_prefix_parser_tb.sv
module insn_prefix_parser_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgOpWide = 1'b1, cfgAddrWide = 1'b1;
  logic [7:0]  inByte = 8'h00;
  logic        inValid = 1'b0;
  logic        inReady, lkReq, lkEscape, lkOpWide;
  logic [7:0]  lkOpcode;
  logic        lkHasDesc, lkUndefined;
  logic [2:0]  lkImm1Code, lkImm2Code;
  logic        dscStart, dscAddrWide;
  logic        dscDone = 1'b0;
  logic [7:0]  dscByte = 8'h00;
  logic        dscHasSib = 1'b0;
  logic [2:0]  dscDispBytes = 3'd0;
  logic        done, invalid, opWide, addrWide, opOvr, addrOvr, lockSeen;
  logic [7:0]  repByte, opcode, subOp;
  logic        segValid, hasSub, hasDesc;
  logic [2:0]  segCode, regIdx;
  logic [3:0]  condCode;
  logic [31:0] imm1, imm2;
  logic [7:0]  length;

  int nChecks = 0, nFails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  insn_prefix_parser u_dut (.*);

  // Bench-side attribute table
  always_comb begin
    lkHasDesc = 1'b0; lkImm1Code = 3'd0; lkImm2Code = 3'd0; lkUndefined = 1'b0;
    if (!lkEscape) begin
      case (lkOpcode)
        8'h90: ;
        8'hB8, 8'hB9, 8'hBA, 8'hBB, 8'hBC, 8'hBD, 8'hBE, 8'hBF:
          lkImm1Code = lkOpWide ? 3'd4 : 3'd2;
        8'h89: lkHasDesc = 1'b1;
        8'hC7: begin lkHasDesc = 1'b1; lkImm1Code = lkOpWide ? 3'd4 : 3'd2; end
        8'hA1: lkImm1Code = 3'd7;
        8'hC8: begin lkImm1Code = 3'd2; lkImm2Code = 3'd1; end
        8'hEA: begin lkImm1Code = 3'd2; lkImm2Code = 3'd7; end
        8'hCC: lkImm1Code = 3'd3;
        default: lkUndefined = 1'b1;
      endcase
    end else begin
      case (lkOpcode)
        8'h84: lkImm1Code = lkOpWide ? 3'd4 : 3'd2;
        8'hAF: lkHasDesc = 1'b1;
        default: lkUndefined = 1'b1;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendB(input logic [7:0] b);
    inByte = b; inValid = 1'b1;
    for (int i = 0; i < 40 && !inReady; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 40 && !(done || invalid); i++) @(negedge clk);
  endtask

  task automatic descStep(input logic [7:0] b, input logic sib, input logic [2:0] disp);
    for (int i = 0; i < 40 && !dscStart; i++) @(negedge clk);
    chk("R11 start seen", dscStart, 1'b1);
    chk("R11 stall at start", inReady, 1'b0);
    @(negedge clk);
    chk("R11 single start", dscStart, 1'b0);
    chk("R11 stall while waiting", inReady, 1'b0);
    dscByte = b; dscHasSib = sib; dscDispBytes = disp; dscDone = 1'b1;
    @(negedge clk);
    dscDone = 1'b0;
  endtask

  task automatic finishDone(input string req);
    @(negedge clk);
    chk({req, " R12 done one cycle"}, done, 1'b0);
    chk("R12 cleared lock", lockSeen, 1'b0);
    chk("R12 cleared seg", segValid, 1'b0);
  endtask

  task automatic tReset();
    chk("R1 ready", inReady, 1'b1);
    chk("R1 done", done, 1'b0);
    chk("R1 invalid", invalid, 1'b0);
    chk("R1 start", dscStart, 1'b0);
    chk("R1 lookup", lkReq, 1'b0);
  endtask

  task automatic tPlain();
    sendB(8'h90); waitEnd();
    chk("R12 done", done, 1'b1);
    chk("R10 length plain", length, 8'd1);
    chk("R6 reg plain", regIdx, 3'd0);
    chk("R3 no rep", repByte, 8'h00);
    chk("R2 default op", opWide, 1'b1);
    chk("R2 no ovr", opOvr, 1'b0);
    finishDone("plain");
  endtask

  task automatic tModifiers();
    sendB(8'h66); sendB(8'h67); sendB(8'hF3); sendB(8'hF0);
    sendB(8'h2E); sendB(8'h64); sendB(8'hF2); sendB(8'hB9);
    sendB(8'h34); sendB(8'h12); waitEnd();
    chk("R2 opWide inverted", opWide, 1'b0);
    chk("R2 addrWide inverted", addrWide, 1'b0);
    chk("R2 op ovr", opOvr, 1'b1);
    chk("R2 addr ovr", addrOvr, 1'b1);
    chk("R3 last rep", repByte, 8'hF2);
    chk("R3 lock", lockSeen, 1'b1);
    chk("R4 seg valid", segValid, 1'b1);
    chk("R4 last seg FS=4", segCode, 3'd4);
    chk("R6 reg from opcode", regIdx, 3'd1);
    chk("R7 cc from opcode", condCode, 4'h9);
    chk("R9 imm1 16-bit", imm1, 32'h1234);
    chk("R10 length with modifiers", length, 8'd10);
    finishDone("mods");
  endtask

  task automatic tDouble();
    sendB(8'h66); sendB(8'h66); sendB(8'hBA); sendB(8'h78); sendB(8'h56); waitEnd();
    chk("R2 double toggle stays inverted", opWide, 1'b0);
    chk("R9 imm1", imm1, 32'h5678);
    chk("R10 length", length, 8'd5);
    finishDone("double");
    sendB(8'h36); sendB(8'h3E); sendB(8'h26); sendB(8'h90); waitEnd();
    chk("R4 last seg ES=0", segCode, 3'd0);
    chk("R4 seg valid", segValid, 1'b1);
    chk("R10 length segs", length, 8'd4);
    finishDone("segs");
  endtask

  task automatic tEscape();
    sendB(8'h0F); sendB(8'h84);
    sendB(8'h44); sendB(8'h33); sendB(8'h22); sendB(8'h11); waitEnd();
    chk("R5 hasSub", hasSub, 1'b1);
    chk("R5 subOp", subOp, 8'h84);
    chk("R7 cc from sub", condCode, 4'h4);
    chk("R6 reg from sub", regIdx, 3'd4);
    chk("R9 imm1 32-bit LE", imm1, 32'h11223344);
    chk("R10 length escape", length, 8'd6);
    finishDone("esc");
  endtask

  task automatic tDesc();
    sendB(8'h89); descStep(8'hD8, 1'b0, 3'd0); waitEnd();
    chk("R6 reg from desc", regIdx, 3'd3);
    chk("R10 length desc", length, 8'd2);
    finishDone("desc");
    sendB(8'h3E); sendB(8'hC7); descStep(8'h84, 1'b1, 3'd4);
    sendB(8'hAA); sendB(8'hBB); sendB(8'hCC); sendB(8'hDD); waitEnd();
    chk("R11 imm after desc", imm1, 32'hDDCCBBAA);
    chk("R6 reg from desc 0", regIdx, 3'd0);
    chk("R10 length full", length, 8'd12);
    finishDone("desc2");
    sendB(8'h0F); sendB(8'hAF); descStep(8'h6B, 1'b0, 3'd1); waitEnd();
    chk("R6 desc beats sub", regIdx, 3'd5);
    chk("R7 cc escape", condCode, 4'hF);
    chk("R10 length esc desc", length, 8'd4);
    finishDone("escdesc");
  endtask

  task automatic tAddrCode();
    sendB(8'hA1); sendB(8'h01); sendB(8'h02); sendB(8'h03); sendB(8'h04); waitEnd();
    chk("R8 code7 wide", imm1, 32'h04030201);
    chk("R8 length wide", length, 8'd5);
    finishDone("aw1");
    sendB(8'h67); sendB(8'hA1); sendB(8'h01); sendB(8'h02); waitEnd();
    chk("R8 code7 narrow", imm1, 32'h0201);
    chk("R8 length narrow", length, 8'd4);
    finishDone("aw0");
    sendB(8'hCC); waitEnd();
    chk("R8 code3 none", length, 8'd1);
    chk("R8 code3 imm", imm1, 32'h0);
    finishDone("code3");
  endtask

  task automatic tOrder();
    sendB(8'hC8); sendB(8'h05); sendB(8'hCD); sendB(8'hAB); waitEnd();
    chk("R9 imm2 first", imm2, 32'h05);
    chk("R9 imm1 second", imm1, 32'hABCD);
    chk("R10 length two imm", length, 8'd4);
    finishDone("order");
    cfgAddrWide = 1'b0;
    sendB(8'hEA); sendB(8'h11); sendB(8'h22); sendB(8'h33); sendB(8'h44); waitEnd();
    chk("R9 imm2 code7 narrow", imm2, 32'h2211);
    chk("R9 imm1 after", imm1, 32'h4433);
    chk("R10 length far", length, 8'd5);
    finishDone("far");
    cfgAddrWide = 1'b1;
  endtask

  task automatic tInvalid();
    sendB(8'hF0); sendB(8'hD6); waitEnd();
    chk("R13 invalid", invalid, 1'b1);
    chk("R13 no done", done, 1'b0);
    @(negedge clk);
    chk("R13 invalid pulse", invalid, 1'b0);
    sendB(8'h90); waitEnd();
    chk("R13 lock cleared", lockSeen, 1'b0);
    chk("R13 length after", length, 8'd1);
    finishDone("after bad");
    sendB(8'h0F); sendB(8'hFF); waitEnd();
    chk("R13 escape invalid", invalid, 1'b1);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPlain();
    tModifiers();
    tDouble();
    tEscape();
    tDesc();
    tAddrCode();
    tOrder();
    tInvalid();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule